// File: doc/BRIEF.md
# Multiplexed Converter Serial Port Controller

This block is the digital control side of an eight-input successive-approximation converter. One active-low select line does two jobs. Its rising edge starts a conversion, and its low phase frames a serial exchange. During that exchange the result is shifted out on a data line that can be released, and a seven-bit setup word is shifted in. The setup word chooses how the inputs are paired, whether the result is straight binary or two's complement, and whether the converter sleeps after the exchange.

The analog part is not modelled. A digital stand-in port (`sample_code`) supplies the raw straight-binary code that the converter would produce. The conversion time is a fixed number of clock cycles set by a parameter. The block drives only the positive and negative input selects of the input switch. SCK, SDI and the select line are oversampled by the system clock, one register stage deep, and their edges are found by comparing that stage with the one before it.

The controller has six named states:
- `ST_IDLE`: powered and waiting.
- `ST_CONV`: a conversion is running.
- `ST_NAP`: the result is ready and the select line is still high.
- `ST_XFER`: an exchange is in progress.
- `ST_SLEEP`: powered down.
- `ST_WAKE`: settling after sleep.

It has these transitions:
- IDLE to CONV, or to SLEEP when the committed sleep bit is set, on a select rise.
- CONV to NAP when the cycle count ends with the select line high.
- CONV to XFER when the count ends with the select line low.
- NAP to XFER when the select line falls.
- XFER to CONV, or to SLEEP when the sleep bit is set, on a select rise.
- SLEEP to WAKE when a word with the sleep bit clear is committed.
- WAKE to IDLE when the wake count ends.

Top module: `adcsp_ctrl`

## Requirements
- R1: A rising edge of `cs_conv` in ST_IDLE or ST_XFER, with the committed sleep bit clear, starts a conversion. `busy` is then high for exactly CONV_CYCLES clock cycles.
- R2: Edges of `cs_conv` during a conversion are ignored: they neither restart it nor lengthen it.
- R3: The setup word is 7 bits, taken MSB first on SCK rising edges while `cs_conv` is low, outside a conversion. The bit order is single-ended, odd, sel1, sel0, com, unipolar, sleep. The word is committed when its 7th bit arrives. Further SDI bits in the same frame are ignored, and the word set after reset is all zeros.
- R4: The result is DATA_W bits, MSB first on `sdo`. Each following bit appears after an SCK falling edge.
- R5: `sdo_en` is 0 whenever `cs_conv` is high and 1 whenever it is low.
- R6: A committed word applies to the next conversion started. When its unipolar bit is 1 the result equals `sample_code`. When the bit is 0 the result is `sample_code` with its MSB inverted (two's complement).
- R7: `mux_pos` = 2·{sel1,sel0} + odd. For a single-ended word, `mux_neg` is 8 (ground) when com is 0 and 7 (common pin) when com is 1. For a differential word, `mux_neg` is the other channel of the pair {sel1,sel0}.
- R8: If `cs_conv` is high when a conversion ends, `nap` rises and stays high until `cs_conv` falls. `sdo_en` stays 0 meanwhile.
- R9: If `cs_conv` is low when a conversion ends, the result MSB appears on `sdo` at once and `nap` stays 0.
- R10: A select rise with the committed sleep bit set enters sleep instead of converting, and `sleep` goes high. Committing a word with the sleep bit clear leaves sleep. Select rises are then ignored for WAKE_CYCLES cycles.
- R11: At most one of `busy`, `nap` and `sleep` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_conv | input | 1 | Select: a rise starts a conversion, low frames the exchange |
| sck | input | 1 | Serial shift clock |
| sdi | input | 1 | Setup word input |
| sample_code | input | DATA_W | Stand-in raw straight-binary converter code |
| sdo | output | 1 | Result serial output |
| sdo_en | output | 1 | Output drive enable for `sdo` (0 means high impedance) |
| busy | output | 1 | Conversion running |
| nap | output | 1 | Nap state |
| sleep | output | 1 | Sleep state |
| mux_pos | output | 4 | Positive input select (0 to 7) |
| mux_neg | output | 4 | Negative input select (0 to 7, 8 means ground) |

## Verification
Each input passes one register stage and one edge-compare stage before the state machine reacts. A select rise therefore raises `busy` after the second clock edge, and `busy` falls CONV_CYCLES edges later. The bench checks `busy` exactly at the last high cycle and at the first low cycle. An SCK edge moves `sdo` or commits a setup bit within two edges, so the bench waits three edges after every pin change and samples half a period after the edge. Nap, sleep and the input selects are checked only after those settling windows. The wake window is probed a few cycles after a select rise, well inside WAKE_CYCLES.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
    localparam int CFG_BITS = 7;
    localparam logic [3:0] SEL_GND = 4'd8;
    localparam logic [3:0] SEL_COM = 4'd7;

    typedef struct packed {
        logic single;
        logic odd;
        logic sel1;
        logic sel0;
        logic com;
        logic unipolar;
        logic sleep;
    } adcsp_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_NAP,
        ST_XFER,
        ST_SLEEP,
        ST_WAKE
    } adcsp_state_t;
endpackage

// File: rtl/adcsp_cfg_rx.sv
module adcsp_cfg_rx
    import adcsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       capture,
    input  logic       sdi,
    output adcsp_cfg_t cfg_o
);
    logic [2:0]          bit_cnt;
    logic [CFG_BITS-2:0] partial;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            partial <= '0;
            cfg_o   <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
        end else if (capture && (bit_cnt < 3'(CFG_BITS))) begin
            partial <= {partial[CFG_BITS-3:0], sdi};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'(CFG_BITS - 1)) begin
                cfg_o <= adcsp_cfg_t'({partial, sdi});
            end
        end
    end
endmodule

// File: rtl/adcsp_mux_map.sv
module adcsp_mux_map
    import adcsp_pkg::*;
(
    input  logic       single,
    input  logic       odd,
    input  logic       sel1,
    input  logic       sel0,
    input  logic       com,
    output logic [3:0] pos,
    output logic [3:0] neg
);
    always_comb begin
        pos = {1'b0, sel1, sel0, odd};
        unique case ({single, com})
            2'b10:   neg = SEL_GND;
            2'b11:   neg = SEL_COM;
            default: neg = {1'b0, sel1, sel0, ~odd};
        endcase
    end
endmodule

// File: rtl/adcsp_out_shift.sv
module adcsp_out_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] raw,
    input  logic              unipolar,
    input  logic              shift,
    output logic              msb
);
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] formatted;

    always_comb begin
        formatted = raw;
        if (!unipolar) begin
            formatted[DATA_W-1] = ~raw[DATA_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= formatted;
        end else if (shift) begin
            sh <= {sh[DATA_W-2:0], 1'b0};
        end
    end

    assign msb = sh[DATA_W-1];
endmodule

// File: rtl/adcsp_ctrl.sv
module adcsp_ctrl
    import adcsp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 185,
    parameter int WAKE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_conv,
    input  logic              sck,
    input  logic              sdi,
    input  logic [DATA_W-1:0] sample_code,
    output logic              sdo,
    output logic              sdo_en,
    output logic              busy,
    output logic              nap,
    output logic              sleep,
    output logic [3:0]        mux_pos,
    output logic [3:0]        mux_neg
);
    localparam int TMR_MAX = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    adcsp_state_t      state_q, state_d;
    logic              cs_q, cs_d, sck_q, sck_d, sdi_q;
    logic              cs_rise, cs_fall, sck_rise, sck_fall;
    logic [TMR_W-1:0]  tmr;
    logic              conv_done, wake_done, start;
    logic [DATA_W-1:0] samp_q;
    logic              uni_q;
    adcsp_cfg_t        cfg;

    // input sampling and edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            cs_d  <= 1'b1;
            sck_q <= 1'b0;
            sck_d <= 1'b0;
            sdi_q <= 1'b0;
        end else begin
            cs_q  <= cs_conv;
            cs_d  <= cs_q;
            sck_q <= sck;
            sck_d <= sck_q;
            sdi_q <= sdi;
        end
    end

    assign cs_rise  = cs_q & ~cs_d;
    assign cs_fall  = ~cs_q & cs_d;
    assign sck_rise = sck_q & ~sck_d;
    assign sck_fall = ~sck_q & sck_d;

    assign conv_done = (state_q == ST_CONV) && (tmr == TMR_W'(CONV_CYCLES - 1));
    assign wake_done = (state_q == ST_WAKE) && (tmr == TMR_W'(WAKE_CYCLES - 1));
    assign start     = (state_d == ST_CONV) && (state_q != ST_CONV);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_XFER: if (cs_rise) state_d = cfg.sleep ? ST_SLEEP : ST_CONV;
            ST_CONV:          if (conv_done) state_d = cs_q ? ST_NAP : ST_XFER;
            ST_NAP:           if (!cs_q) state_d = ST_XFER;
            ST_SLEEP:         if (!cfg.sleep) state_d = ST_WAKE;
            ST_WAKE:          if (wake_done) state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // state register, interval timer and sample hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr     <= '0;
            samp_q  <= '0;
            uni_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                tmr <= '0;
            end else if (state_q == ST_CONV || state_q == ST_WAKE) begin
                tmr <= tmr + TMR_W'(1);
            end
            if (start) begin
                samp_q <= sample_code;
                uni_q  <= cfg.unipolar;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy  = 1'b0;
        nap   = 1'b0;
        sleep = 1'b0;
        unique case (state_q)
            ST_CONV:  busy  = 1'b1;
            ST_NAP:   nap   = 1'b1;
            ST_SLEEP: sleep = 1'b1;
            default:  ;
        endcase
        sdo_en = ~cs_q;
    end

    adcsp_cfg_rx u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cs_fall),
        .capture (sck_rise && !cs_q && (state_q != ST_CONV)),
        .sdi     (sdi_q),
        .cfg_o   (cfg)
    );

    adcsp_mux_map u_mux (
        .single (cfg.single),
        .odd    (cfg.odd),
        .sel1   (cfg.sel1),
        .sel0   (cfg.sel0),
        .com    (cfg.com),
        .pos    (mux_pos),
        .neg    (mux_neg)
    );

    adcsp_out_shift #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (conv_done),
        .raw      (samp_q),
        .unipolar (uni_q),
        .shift    (sck_fall && (state_q == ST_XFER)),
        .msb      (sdo)
    );
endmodule

// File: rtl/adcsp_ctrl_chk.sv
module adcsp_ctrl_chk #(
    parameter int CONV_CYCLES = 185
) (
    input logic clk,
    input logic rst_n,
    input logic cs_conv,
    input logic sdo_en,
    input logic busy,
    input logic nap,
    input logic sleep
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1) + 1;

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + CNT_W'(1);
        else           run_cnt <= '0;
    end

    p_busy_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_cnt) == CNT_W'(CONV_CYCLES - 1)));

    p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < CNT_W'(CONV_CYCLES)));

    p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_conv && $past(cs_conv)) |=> !sdo_en);

    p_start_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(sleep) && !$past(nap)));

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, nap, sleep}));
endmodule

bind adcsp_ctrl adcsp_ctrl_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_conv (cs_conv),
    .sdo_en  (sdo_en),
    .busy    (busy),
    .nap     (nap),
    .sleep   (sleep)
);

// File: tb/adcsp_ctrl_tb.sv
module adcsp_ctrl_tb;
    localparam int DW    = 16;
    localparam int CONV  = 185;
    localparam int WAKE  = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_conv = 1'b1;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic [DW-1:0] sample_code = '0;
    logic          sdo, sdo_en, busy, nap, sleep;
    logic [3:0]    mux_pos, mux_neg;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic cur_uni = 1'b0;

    always #10 clk = ~clk;

    adcsp_ctrl #(.DATA_W(DW), .CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_conv(cs_conv), .sck(sck), .sdi(sdi),
        .sample_code(sample_code), .sdo(sdo), .sdo_en(sdo_en), .busy(busy),
        .nap(nap), .sleep(sleep), .mux_pos(mux_pos), .mux_neg(mux_neg)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_result(input logic [DW-1:0] s, input logic uni);
        return uni ? s : (s ^ (1 << (DW - 1)));
    endfunction

    function automatic logic [7:0] exp_mux(input logic [6:0] c);
        logic [3:0] p, n;
        p = 4'(c[4:3]) * 4'd2 + 4'(c[5]);
        if (c[6]) n = c[2] ? 4'd7 : 4'd8;
        else      n = 4'(c[4:3]) * 4'd2 + 4'(!c[5]);
        return {p, n};
    endfunction

    task automatic frame(input logic [6:0] c, output logic [DW-1:0] got);
        for (int i = 0; i < DW; i++) begin
            got[DW-1-i] = sdo;
            sdi = (i < 7) ? c[6-i] : 1'($urandom);
            step(3);
            sck = 1'b1;
            step(3);
            sck = 1'b0;
            step(3);
        end
    endtask

    task automatic convert_and_read(input bit early, input bit glitch,
                                    input logic [DW-1:0] s, input logic [6:0] c);
        logic [DW-1:0] got, exp;
        exp = exp_result(s, cur_uni);
        sample_code = s;
        cs_conv = 1'b1;
        if (early) begin
            step(10);
            cs_conv = 1'b0;
            step(CONV + 1 - 10);
            chk("R1", "busy at last cycle", busy, 1);
            step(1);
            chk("R1", "busy after end", busy, 0);
            chk("R9", "nap with cs low", nap, 0);
            chk("R9", "msb at end", sdo, exp[DW-1]);
        end else begin
            if (glitch) begin
                step(50);
                cs_conv = 1'b0;
                step(3);
                cs_conv = 1'b1;
                step(CONV + 1 - 53);
            end else begin
                step(CONV + 1);
            end
            chk("R2", "busy at last cycle", busy, 1);
            step(1);
            chk("R2", "busy after end", busy, 0);
            chk("R8", "nap", nap, 1);
            chk("R5", "sdo_en cs high", sdo_en, 0);
            cs_conv = 1'b0;
            step(3);
            chk("R8", "nap after cs fall", nap, 0);
            chk("R5", "sdo_en cs low", sdo_en, 1);
        end
        frame(c, got);
        chk("R4", "result word", got, exp);
        chk("R7", "mux selects", {mux_pos, mux_neg}, exp_mux(c));
        cur_uni = c[1];
    endtask

    initial begin
        logic [DW-1:0] dummy;
        logic [6:0] c;
        void'($urandom(32'd5150));
        step(4);
        rst_n = 1'b1;
        step(2);
        chk("R11", "reset busy", busy, 0);
        chk("R11", "reset nap", nap, 0);
        chk("R10", "reset sleep", sleep, 0);
        chk("R5", "reset sdo_en", sdo_en, 0);
        chk("R3", "reset mux zero word", {mux_pos, mux_neg}, 8'h01);
        cs_conv = 1'b0;
        step(3);

        // directed corners: zero and full-scale in both formats
        convert_and_read(0, 0, 16'h0000, 7'b1000010);   // R6 bipolar -> 8000
        convert_and_read(0, 0, 16'hFFFF, 7'b0100000);   // R6 unipolar -> FFFF
        convert_and_read(1, 0, 16'h8000, 7'b1101100);   // R6 bipolar -> 0000
        convert_and_read(0, 1, 16'h7FFF, 7'b0011010);   // R2 restart attempt
        for (int k = 0; k < 20; k++) begin
            c = 7'($urandom) & 7'h7E;
            convert_and_read(1'($urandom), 1'($urandom), DW'($urandom), c);
        end

        // R10 sleep entry, exit and wake window
        convert_and_read(0, 0, 16'h1234, 7'b1100011);
        cs_conv = 1'b1;
        step(3);
        chk("R10", "sleep entered", sleep, 1);
        chk("R10", "no conversion in sleep", busy, 0);
        cs_conv = 1'b0;
        step(3);
        c = 7'b0110010;
        frame(c, dummy);
        chk("R10", "sleep left", sleep, 0);
        cs_conv = 1'b1;
        step(5);
        chk("R10", "rise during wake ignored", busy, 0);
        step(WAKE);
        cs_conv = 1'b0;
        step(3);
        cur_uni = c[1];
        convert_and_read(0, 0, 16'hA5C3, 7'b1011100);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule